// File: doc/BRIEF.md
# Dual-Clock Queue with Per-Domain Fill Counts

This block is a first-in first-out queue that connects a producer and a consumer running on unrelated clocks. The producer pushes words on its own clock. The consumer pops them on its own clock. Each side resets asynchronously and independently of the other.

Each side keeps a binary position counter and a Gray-coded copy of that counter. The Gray copy is the only thing that crosses to the other clock. There it passes through a chain of destination-clock flip-flops and is converted back to binary. Each side subtracts that converted value from its own counter, which gives it a fill count it can use without any further crossing. The producer sees a full flag and a count of occupied slots. The consumer sees an empty flag, the same kind of count, and the word at the head of the queue, which is valid whenever empty is low.

The storage holds a power-of-two number of words. The counters carry one bit more than the slot address, so a completely full queue and an empty one can be told apart.

Top module: `dual_clock_queue`

## Requirements
- R1: After both resets, empty is 1, full is 0, and both fill counts are 0.
- R2: Words come out on the read side in exactly the order they were accepted on the write side, and pointer wrap-around does not disturb this. `rdData` shows the head word whenever `rdEmpty` is 0, and a pop is a read-clock edge with `rdEn` high.
- R3: A write presented while full is dropped. The write position does not move, the count stays at the capacity, and no stored word is replaced.
- R4: A read presented while empty is dropped. The read position does not move, the read-side count stays 0, and the next word written is the next word read.
- R5: Full is high exactly when the write-side count equals the capacity (2^ADDR_W). After 2^ADDR_W accepted writes with no reads, full is high by the following write-clock edge.
- R6: The write-side count is ADDR_W+1 bits wide and never exceeds the capacity. Once traffic stops, it settles within a few write clocks to the number of words held.
- R7: The read-side count never exceeds the capacity and is 0 exactly when empty is high. Once traffic stops, it settles within a few read clocks to the number of words held.
- R8: Each side's Gray-coded position changes by at most one bit per own-clock edge, including across the wrap. As a result, the read-side count never falls except by a pop, and the write-side count never rises except by an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Producer clock |
| wrRstN | input | 1 | Producer-side asynchronous reset, active low |
| wrEn | input | 1 | Push request |
| wrData | input | DATA_W | Word to push |
| wrFull | output | 1 | No free slot as seen by the producer |
| wrLevel | output | ADDR_W+1 | Occupied slots as seen by the producer |
| rdClk | input | 1 | Consumer clock |
| rdRstN | input | 1 | Consumer-side asynchronous reset, active low |
| rdEn | input | 1 | Pop request |
| rdData | output | DATA_W | Head word, valid while rdEmpty is 0 |
| rdEmpty | output | 1 | No word available as seen by the consumer |
| rdLevel | output | ADDR_W+1 | Occupied slots as seen by the consumer |

## Verification
The hardest state to reach from the ports is a position counter wrapping past its top value while the other side is working at a different rate. That is where a bad Gray conversion or a bad full comparison corrupts the counts. The stimulus sends thousands of random pushes and pops from clocks with unrelated periods, so the pointers wrap many times. It runs once with writes dominating, which keeps the queue pinned at full, and once with reads dominating, which keeps it pinned at empty. Directed steps separately force pushes into a full queue and pops from an empty one, then let both sides settle and compare each count and every word read out against a bench-side model.

// File: rtl/dcq_pkg.sv
`timescale 1ns/1ps
package dcq_pkg;
  // Selects which clock domain a position keeper serves.
  typedef enum logic {
    SIDE_WR = 1'b0,
    SIDE_RD = 1'b1
  } dcqSide_t;
endpackage

// File: rtl/dcq_sync.sv
`timescale 1ns/1ps
// Chain of destination-clock flops for a Gray-coded position.
module dcq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dcq_ptr.sv
`timescale 1ns/1ps
// Position keeper for one clock domain: binary and Gray counters,
// synchronizer for the far side's Gray position, flag and fill count.
module dcq_ptr
  import dcq_pkg::*;
#(
  parameter int       ADDR_W      = 3,
  parameter int       SYNC_STAGES = 2,
  parameter dcqSide_t SIDE        = SIDE_WR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W:0]   farGray,
  output logic              fire,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   ownGray,
  output logic              flag,
  output logic [ADDR_W:0]   level
);
  localparam int PTR_W = ADDR_W + 1;
  // Top two Gray bits inverted marks a lap's difference (ADDR_W >= 2).
  localparam logic [PTR_W-1:0] LAP_MASK = {2'b11, {(PTR_W-2){1'b0}}};

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] ownBin;
  logic [PTR_W-1:0] nextBin;
  logic [PTR_W-1:0] farSeen;
  logic [PTR_W-1:0] farBin;

  dcq_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_farSync (
    .clk (clk),
    .rstN(rstN),
    .din (farGray),
    .dout(farSeen)
  );

  assign farBin  = fromGray(farSeen);
  assign fire    = req & ~flag;
  assign nextBin = ownBin + PTR_W'(fire);
  assign addr    = ownBin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownBin  <= '0;
      ownGray <= '0;
    end else begin
      ownBin  <= nextBin;
      ownGray <= toGray(nextBin);
    end
  end

  generate
    if (SIDE == SIDE_WR) begin : g_wrSide
      assign flag  = (ownGray == (farSeen ^ LAP_MASK));
      assign level = ownBin - farBin;
    end else begin : g_rdSide
      assign flag  = (ownGray == farSeen);
      assign level = farBin - ownBin;
    end
  endgenerate
endmodule

// File: rtl/dcq_store.sv
`timescale 1ns/1ps
// Register array: written on the producer clock, read combinationally
// at the consumer's head slot.
module dcq_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              wrFire,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] cellView;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    logic [DATA_W-1:0] word;
    always_ff @(posedge wrClk) begin
      if (wrFire && (wrAddr == ADDR_W'(e))) word <= wrData;
    end
    assign cellView[e] = word;
  end

  assign rdData = cellView[rdAddr];
endmodule

// File: rtl/dual_clock_queue.sv
`timescale 1ns/1ps
module dual_clock_queue
  import dcq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic [ADDR_W:0]   wrLevel,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic [ADDR_W:0]   rdLevel
);
  logic              wrFire;
  logic              rdFire;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W:0]   wGray;
  logic [ADDR_W:0]   rGray;

  dcq_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_WR)) u_wrPtr (
    .clk    (wrClk),
    .rstN   (wrRstN),
    .req    (wrEn),
    .farGray(rGray),
    .fire   (wrFire),
    .addr   (wrAddr),
    .ownGray(wGray),
    .flag   (wrFull),
    .level  (wrLevel)
  );

  dcq_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_RD)) u_rdPtr (
    .clk    (rdClk),
    .rstN   (rdRstN),
    .req    (rdEn),
    .farGray(wGray),
    .fire   (rdFire),
    .addr   (rdAddr),
    .ownGray(rGray),
    .flag   (rdEmpty),
    .level  (rdLevel)
  );

  dcq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk (wrClk),
    .wrFire(wrFire),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/dcq_checker.sv
`timescale 1ns/1ps
module dcq_checker #(
  parameter int ADDR_W = 3
) (
  input logic            wrClk,
  input logic            wrRstN,
  input logic            wrEn,
  input logic            wrFull,
  input logic            wrFire,
  input logic [ADDR_W:0] wrLevel,
  input logic [ADDR_W:0] wGray,
  input logic            rdClk,
  input logic            rdRstN,
  input logic            rdEn,
  input logic            rdEmpty,
  input logic            rdFire,
  input logic [ADDR_W:0] rdLevel,
  input logic [ADDR_W:0] rGray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(1) << ADDR_W;

  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull && wrEn |=> $stable(wGray));
  p_write_room_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFire |-> wrLevel < CAP);
  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty && rdEn |=> $stable(rGray));
  p_full_level_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |-> wrLevel == CAP);
  p_wr_level_cap_r6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrLevel <= CAP);
  p_rd_level_cap_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdLevel <= CAP);
  p_empty_level_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty |-> rdLevel == '0);
  p_level_empty_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdLevel == '0 |-> rdEmpty);
  p_pop_has_data_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdFire |-> rdLevel != '0);
  p_wgray_step_r8: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wGray ^ $past(wGray)) <= 1);
  p_rgray_step_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rGray ^ $past(rGray)) <= 1);
  p_rd_level_rise_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdFire |=> rdLevel >= $past(rdLevel));
endmodule

bind dual_clock_queue dcq_checker #(.ADDR_W(ADDR_W)) u_dcqCheck (
  .wrClk  (wrClk),
  .wrRstN (wrRstN),
  .wrEn   (wrEn),
  .wrFull (wrFull),
  .wrFire (wrFire),
  .wrLevel(wrLevel),
  .wGray  (wGray),
  .rdClk  (rdClk),
  .rdRstN (rdRstN),
  .rdEn   (rdEn),
  .rdEmpty(rdEmpty),
  .rdFire (rdFire),
  .rdLevel(rdLevel),
  .rGray  (rGray)
);

// File: tb/tb_dual_clock_queue.sv
`timescale 1ns/1ps
module tb_dual_clock_queue;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wrClk = 0, rdClk = 0;
  logic              wrRstN, rdRstN, wrEn, rdEn;
  logic [DATA_W-1:0] wrData, rdData;
  logic              wrFull, rdEmpty;
  logic [ADDR_W:0]   wrLevel, rdLevel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [DATA_W-1:0] model[$];

  always #4   wrClk = ~wrClk;   // 125 MHz
  always #6.5 rdClk = ~rdClk;

  dual_clock_queue #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrLevel(wrLevel),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdLevel(rdLevel)
  );

  function automatic int expLevel();
    return model.size();
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrDrive(input logic [DATA_W-1:0] d);
    @(negedge wrClk);
    wrEn = 1; wrData = d;
    if (!wrFull) model.push_back(d);
  endtask

  task automatic wrIdle();
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic rdTake(input string tag);
    @(negedge rdClk);
    if (rdEmpty || model.size() == 0) begin
      chk(0, tag, rdEmpty, 0);
      rdEn = 0;
    end else begin
      chk(rdData == model[0], tag, rdData, model[0]);
      rdEn = 1;
      void'(model.pop_front());
    end
  endtask

  task automatic rdIdle();
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic levelsMatch(input string tag);
    chk(wrLevel == expLevel(), {"R6 ", tag}, wrLevel, expLevel());
    chk(rdLevel == expLevel(), {"R7 ", tag}, rdLevel, expLevel());
    chk(rdEmpty == (expLevel() == 0), {"R7 empty ", tag}, rdEmpty, expLevel() == 0);
  endtask

  task automatic randWriter(input int cycles, input int pct);
    int prevLvl;
    bit prevAcc;
    prevLvl = wrLevel;
    prevAcc = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge wrClk);
      chk(wrLevel <= DEPTH, "R6 write count cap", wrLevel, DEPTH);
      chk(wrFull == (wrLevel == DEPTH), "R5 full tracks count", wrFull, wrLevel == DEPTH);
      chk(int'(wrLevel) <= prevLvl + int'(prevAcc), "R8 write count rise",
          wrLevel, prevLvl + int'(prevAcc));
      prevLvl = wrLevel;
      wrEn    = ($urandom_range(99) < pct);
      wrData  = DATA_W'($urandom);
      prevAcc = wrEn && !wrFull;
      if (prevAcc) model.push_back(wrData);
    end
    wrIdle();
  endtask

  task automatic randReader(input int cycles, input int pct);
    int prevLvl;
    bit prevFire;
    prevLvl  = rdLevel;
    prevFire = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge rdClk);
      chk(rdLevel <= DEPTH, "R7 read count cap", rdLevel, DEPTH);
      chk(rdEmpty == (rdLevel == 0), "R7 empty tracks count", rdEmpty, rdLevel == 0);
      chk(int'(rdLevel) >= prevLvl - int'(prevFire), "R8 read count fall",
          rdLevel, prevLvl - int'(prevFire));
      prevLvl = rdLevel;
      if (!rdEmpty && ($urandom_range(99) < pct)) begin
        if (model.size() == 0) begin
          chk(0, "R2 design has data the model lacks", 1, 0);
          rdEn = 0;
        end else begin
          chk(rdData == model[0], "R2 random order", rdData, model[0]);
          void'(model.pop_front());
          rdEn = 1;
        end
      end else begin
        rdEn = 0;
      end
      prevFire = rdEn;
    end
    rdIdle();
  endtask

  initial begin
    #500000;
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    wrRstN = 0; rdRstN = 0; wrEn = 0; rdEn = 0; wrData = '0;
    repeat (3) @(negedge wrClk);
    wrRstN = 1;
    @(negedge rdClk);
    rdRstN = 1;
    @(negedge rdClk);
    // R1 reset state
    chk(rdEmpty == 1, "R1 empty after reset", rdEmpty, 1);
    chk(rdLevel == 0, "R1 read count after reset", rdLevel, 0);
    @(negedge wrClk);
    chk(wrFull == 0, "R1 full after reset", wrFull, 0);
    chk(wrLevel == 0, "R1 write count after reset", wrLevel, 0);

    // R4 pops on an empty queue are dropped
    @(negedge rdClk); rdEn = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge rdClk);
      chk(rdEmpty == 1, "R4 stays empty", rdEmpty, 1);
      chk(rdLevel == 0, "R4 read count stays 0", rdLevel, 0);
    end
    rdEn = 0;
    wrDrive(8'h5A);
    wrIdle();
    settle();
    levelsMatch("one word after empty pops");
    chk(rdData == 8'h5A, "R4 next word read after empty pops", rdData, 8'h5A);
    rdTake("R4 pop after empty pops");
    rdIdle();
    settle();
    levelsMatch("back to empty");

    // R5 / R3 fill, then push into full
    for (int i = 0; i < DEPTH; i++) begin
      wrDrive(DATA_W'(8'h10 + i));
      chk(wrFull == 0, "R5 not full early", wrFull, 0);
    end
    @(negedge wrClk);
    chk(wrFull == 1, "R5 full after capacity writes", wrFull, 1);
    chk(wrLevel == DEPTH, "R5 count at capacity", wrLevel, DEPTH);
    wrData = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge wrClk);
      chk(wrFull == 1, "R3 stays full", wrFull, 1);
      chk(wrLevel == DEPTH, "R3 count held", wrLevel, DEPTH);
    end
    wrEn = 0;
    chk(expLevel() == DEPTH, "R5 all capacity writes accepted", expLevel(), DEPTH);
    settle();
    levelsMatch("full queue");
    for (int k = 0; k < DEPTH; k++) rdTake("R3 words intact after dropped writes");
    rdIdle();
    settle();
    levelsMatch("drained");

    // R6 / R7 partial occupancy
    for (int i = 0; i < 5; i++) wrDrive(DATA_W'(8'hA0 + i));
    wrIdle();
    settle();
    levelsMatch("five held");
    rdTake("R2 partial pop");
    rdTake("R2 partial pop");
    rdIdle();
    settle();
    levelsMatch("three held");
    for (int k = 0; k < 3; k++) rdTake("R2 partial drain");
    rdIdle();
    settle();

    // Random traffic: write-heavy, then read-heavy (R2 wraps many times)
    fork
      randWriter(1500, 75);
      randReader(900, 35);
    join
    settle();
    levelsMatch("after write-heavy traffic");
    fork
      randWriter(1200, 30);
      randReader(1500, 85);
    join
    settle();
    levelsMatch("after read-heavy traffic");
    while (model.size() > 0) rdTake("R2 final drain");
    rdIdle();
    settle();
    levelsMatch("final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule